// File: doc/BRIEF.md
# PCI Master Abort Completion Logic

This block turns the outcome of a transaction that the bridge mastered on PCI into a completion for the internal requester. The PCI master engine reports each finished transaction with a one-cycle strobe, along with the request's cycle type, its length in dwords, its tag, the read data it collected and how the bus ended the transfer. One clock later the block returns a completion code, the data for the requester and single-cycle pulses. The pulses set the received-master-abort and received-target-abort status bits and the first-error flag for the PCI side.

The response depends on the length and the cycle type. A master abort on a single-dword memory access completes quietly: a read returns all ones and a write completes normally. A master abort on a longer memory access returns a hard fail. A master abort on a configuration cycle completes normally and is not logged as a first error. A target abort always returns a hard fail.

Top module: `pci_abort_cpl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cpl_valid`, `cpl_code`, `cpl_tag`, `cpl_data`, `set_rma`, `set_rta` and `set_ferr` are all zero.
- R2: A transfer with termination code 2'b00 (normal) completes with code 2'b00 (normal) and raises no flag pulse. Read data on `rd_data_in` is passed through unchanged for memory read (kind 2'b00) and configuration read (kind 2'b10). Writes (kinds 2'b01 and 2'b11) return zero data.
- R3: A master abort (termination 2'b01) on a memory read of exactly one dword completes with code 2'b00 and data of all ones, and pulses both `set_rma` and `set_ferr`.
- R4: A master abort on a memory read longer than one dword completes with code 2'b01 (hard fail) and zero data, and pulses `set_rma` and `set_ferr`.
- R5: A master abort on a memory write completes with code 2'b00 when the length is one dword and 2'b01 otherwise. The data is zero, and `set_rma` and `set_ferr` both pulse.
- R6: A master abort on a configuration cycle (kind 2'b10 or 2'b11), of any length, completes with code 2'b00 and pulses `set_rma` but not `set_ferr`. A configuration read returns all ones and a configuration write returns zero.
- R7: A target abort (termination 2'b10, with 2'b11 treated the same) on any cycle type completes with code 2'b01 and zero data, pulses `set_rta` and `set_ferr`, and never pulses `set_rma`.
- R8: Each completion appears exactly one cycle after `term_valid` is sampled high, lasts one cycle and echoes `req_tag`. Flag pulses occur only in that cycle. With `term_valid` low the next cycle shows no valid and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| term_valid | input | 1 | One-cycle strobe: a mastered transaction has ended |
| req_kind | input | 2 | 00 mem read, 01 mem write, 10 cfg read, 11 cfg write |
| req_len | input | LEN_W | Transfer length in dwords (1 = single dword) |
| req_tag | input | TAG_W | Requester tag to echo |
| term_code | input | 2 | 00 normal, 01 master abort, 10/11 target abort |
| rd_data_in | input | DATA_W | Read data collected from the bus |
| cpl_valid | output | 1 | Completion strobe |
| cpl_code | output | 2 | 00 normal, 01 hard fail |
| cpl_tag | output | TAG_W | Echoed tag |
| cpl_data | output | DATA_W | Data returned to the requester |
| set_rma | output | 1 | Pulse: set received-master-abort status |
| set_rta | output | 1 | Pulse: set received-target-abort status |
| set_ferr | output | 1 | Pulse: set first-error PCI flag |

## Verification
Random transfers cover every cycle type and termination code, with lengths drawn so that about half are exactly one dword. This separates single-dword from multi-dword behaviour and memory from configuration logging. Directed cases pin the boundary at lengths one and two, the maximum length, the reserved termination code and random read data on normal and aborted reads. These show whether data is passed through or replaced with all ones. Idle gaps between strobes show that completions and pulses last a single cycle and that nothing appears without a strobe.

// File: rtl/pci_abort_cpl.sv
module pci_abort_cpl #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              term_valid,
  input  logic [1:0]        req_kind,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [1:0]        term_code,
  input  logic [DATA_W-1:0] rd_data_in,
  output logic              cpl_valid,
  output logic [1:0]        cpl_code,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic [DATA_W-1:0] cpl_data,
  output logic              set_rma,
  output logic              set_rta,
  output logic              set_ferr
);
  localparam logic [1:0] CodeNormal = 2'b00;
  localparam logic [1:0] CodeHard   = 2'b01;

  logic is_rd, is_cfg, single, ma, ta, hard, ones;
  logic [DATA_W-1:0] data_nxt;

  assign is_rd  = ~req_kind[0];
  assign is_cfg = req_kind[1];
  assign single = (req_len == LEN_W'(1));
  assign ma     = (term_code == 2'b01);
  assign ta     = term_code[1];
  assign hard   = ta | (ma & ~is_cfg & ~single);
  assign ones   = ma & is_rd & (is_cfg | single);

  always_comb begin
    if (hard)       data_nxt = '0;
    else if (ones)  data_nxt = '1;
    else if (is_rd) data_nxt = rd_data_in;
    else            data_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpl_valid <= 1'b0;
      cpl_code  <= CodeNormal;
      cpl_tag   <= '0;
      cpl_data  <= '0;
      set_rma   <= 1'b0;
      set_rta   <= 1'b0;
      set_ferr  <= 1'b0;
    end else begin
      cpl_valid <= term_valid;
      cpl_code  <= (term_valid && hard) ? CodeHard : CodeNormal;
      cpl_tag   <= term_valid ? req_tag : '0;
      cpl_data  <= term_valid ? data_nxt : '0;
      set_rma   <= term_valid & ma;
      set_rta   <= term_valid & ta;
      set_ferr  <= term_valid & (ta | (ma & ~is_cfg));
    end
  end

  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (set_rma | set_rta | set_ferr) |-> cpl_valid); // R8
  AST_VALID_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid |=> cpl_valid && cpl_tag == $past(req_tag)); // R8
  AST_ABORT_KINDS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_rma && set_rta)); // R7
  AST_HARD_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_code == CodeHard) |-> cpl_data == '0); // R4
  AST_CFG_NO_FERR: assert property (@(posedge clk) disable iff (!rst_n)
    (term_valid && req_kind[1] && term_code == 2'b01) |=> set_rma && !set_ferr && cpl_code == CodeNormal); // R6
  AST_TA_HARD: assert property (@(posedge clk) disable iff (!rst_n)
    (term_valid && term_code[1]) |=> cpl_code == CodeHard && set_ferr); // R7
endmodule

// File: tb/pci_abort_cpl_tb.sv
module pci_abort_cpl_tb;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 4;
  localparam int TAG_W  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic term_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [1:0] term_code = '0;
  logic [DATA_W-1:0] rd_data_in = '0;
  logic cpl_valid, set_rma, set_rta, set_ferr;
  logic [1:0] cpl_code;
  logic [TAG_W-1:0] cpl_tag;
  logic [DATA_W-1:0] cpl_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pci_abort_cpl #(.DATA_W(DATA_W), .LEN_W(LEN_W), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .term_valid(term_valid), .req_kind(req_kind),
    .req_len(req_len), .req_tag(req_tag), .term_code(term_code),
    .rd_data_in(rd_data_in), .cpl_valid(cpl_valid), .cpl_code(cpl_code),
    .cpl_tag(cpl_tag), .cpl_data(cpl_data), .set_rma(set_rma),
    .set_rta(set_rta), .set_ferr(set_ferr));

  function automatic string req_of(input logic [1:0] k, input logic [LEN_W-1:0] l, input logic [1:0] t);
    if (t == 2'b00) return "R2";
    if (t[1]) return "R7";
    if (k[1]) return "R6";
    if (k[0]) return "R5";
    return (l == 1) ? "R3" : "R4";
  endfunction

  function automatic logic [1:0] exp_code(input logic [1:0] k, input logic [LEN_W-1:0] l, input logic [1:0] t);
    if (t[1]) return 2'b01;
    if (t == 2'b01 && !k[1] && l != 1) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DATA_W-1:0] exp_data(input logic [1:0] k, input logic [LEN_W-1:0] l,
                                                 input logic [1:0] t, input logic [DATA_W-1:0] d);
    if (exp_code(k, l, t) == 2'b01) return '0;
    if (k[0]) return '0;
    if (t == 2'b01) return '1;
    return d;
  endfunction

  task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic run_one(input logic [1:0] k, input logic [LEN_W-1:0] l, input logic [1:0] t,
                         input logic [TAG_W-1:0] g, input logic [DATA_W-1:0] d, input bit gap);
    string r;
    logic [2:0] fl;
    r = req_of(k, l, t);
    fl = {t == 2'b01, t[1], t[1] | (t == 2'b01 && !k[1])};
    @(negedge clk);
    term_valid = 1'b1; req_kind = k; req_len = l; term_code = t; req_tag = g; rd_data_in = d;
    @(negedge clk);
    term_valid = 1'b0; req_kind = ~k; term_code = ~t; rd_data_in = ~d;
    chk("R8", "valid", 64'(cpl_valid), 64'(1));
    chk("R8", "tag", 64'(cpl_tag), 64'(g));
    chk(r, "code", 64'(cpl_code), 64'(exp_code(k, l, t)));
    chk(r, "data", 64'(cpl_data), 64'(exp_data(k, l, t, d)));
    chk(r, "flags rma/rta/ferr", 64'({set_rma, set_rta, set_ferr}), 64'(fl));
    if (gap) begin
      @(negedge clk);
      chk("R8", "idle valid/flags", 64'({cpl_valid, set_rma, set_rta, set_ferr}), 64'(0));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", 64'({cpl_valid, cpl_code, set_rma, set_rta, set_ferr}), 64'(0));
    chk("R1", "data/tag in reset", 64'({cpl_tag, cpl_data}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset", 64'({cpl_valid, set_rma, set_rta, set_ferr}), 64'(0));

    run_one(2'b00, 1, 2'b00, 5'd3, 32'h1234_5678, 1'b1);  // R2 read pass-through
    run_one(2'b01, 4, 2'b00, 5'd4, 32'hdead_beef, 1'b0);  // R2 write zero data
    run_one(2'b00, 1, 2'b01, 5'd5, 32'h0000_0001, 1'b1);  // R3 all ones
    run_one(2'b00, 2, 2'b01, 5'd6, 32'h5555_aaaa, 1'b0);  // R4 boundary len 2
    run_one(2'b00, 15, 2'b01, 5'd7, 32'h1, 1'b0);         // R4 max length
    run_one(2'b01, 1, 2'b01, 5'd8, 32'h2, 1'b0);          // R5 single write
    run_one(2'b01, 2, 2'b01, 5'd9, 32'h3, 1'b1);          // R5 multi write
    run_one(2'b10, 1, 2'b01, 5'd10, 32'h4, 1'b0);         // R6 cfg read
    run_one(2'b11, 3, 2'b01, 5'd11, 32'h5, 1'b0);         // R6 cfg write
    run_one(2'b00, 1, 2'b10, 5'd12, 32'h6, 1'b0);         // R7 single read TA
    run_one(2'b01, 1, 2'b11, 5'd13, 32'h7, 1'b1);         // R7 reserved code as TA
    run_one(2'b10, 1, 2'b00, 5'd14, 32'hcafe_f00d, 1'b0); // R2 cfg read pass-through

    for (int i = 0; i < 400; i++) begin
      logic [LEN_W-1:0] l;
      l = ($urandom_range(0, 1) == 0) ? LEN_W'(1) : LEN_W'($urandom_range(2, 15));
      run_one(2'($urandom), l, 2'($urandom), TAG_W'($urandom), $urandom, ($urandom_range(0, 3) == 0));
    end

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule